// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over several clock cycles. It uses one double-width product register, an adder, and a two-bit control state machine. The multiplier operand goes into the low half of the product register. On each iteration the block looks at the lowest bit. If that bit is set, the multiplicand is added into the upper half. The whole register then shifts right by one place, and the adder's carry-out becomes the new top bit. After one iteration per multiplier bit, the full product sits in the register.

The controller has four states, each with a fixed two-bit code: INIT=00, ADD=01, SHIFT=10, HALT=11. The completion flag is a decode of the registered HALT code. It stays high for as long as the controller rests in HALT. A START pulse sampled in HALT begins a new run. While the block is idle, the product output keeps the previous result.

Top module: `seq_mult`

## Requirements
- R1: Synchronous active-high reset puts the controller in HALT (code 11), sets `done` to 1, and clears `product` to 0.
- R2: `done` is 1 exactly when the state code is 11 (HALT), and 0 in INIT (00), ADD (01) and SHIFT (10).
- R3: `start` sampled high in HALT moves the controller to INIT on that edge, so `done` is 0 in the following cycle.
- R4: In INIT the upper half of the product register is cleared and `mplier` is loaded into the lower half. The next state is ADD.
- R5: In ADD the multiplicand is added into the upper half when product bit 0 is 1. The carry-out is kept for the following shift. The next state is SHIFT.
- R6: In SHIFT the register shifts right by one bit, with the stored carry entering bit 15. After the 8th SHIFT the controller enters HALT, otherwise it returns to ADD.
- R7: A run takes exactly 2 + 2*8 = 18 clock edges from the edge that samples `start` to the edge that raises `done`. At that point `product` equals `mcand * mplier` as unsigned numbers.
- R8: While the controller stays in HALT with `start` low, `product` keeps its value and changes in no cycle.
- R9: `start`, `mcand` and `mplier` have no effect while a run is in progress. Only the operands latched at START are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mcand | input | 8 | Multiplicand, unsigned |
| mplier | input | 8 | Multiplier, unsigned |
| start | input | 1 | Begins a run when sampled in HALT |
| product | output | 16 | Product register contents |
| done | output | 1 | High while in HALT |

## Verification
Two events can fall in the same cycle: the last SHIFT, which must end the run, and a `start` that is already high. The bench keeps `start` asserted across whole runs and changes the operand inputs in mid-run. A correct design finishes with the product of the operands latched at start, holds `done` for exactly one cycle, and only then begins the next run. The bench also sweeps every 8-bit multiplicand against a set of multipliers that includes the zero, one, all-ones and alternating-bit corners. Each result is compared with arithmetic products computed in the bench, and the bench counts the exact edge at which `done` rises.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'b00,
    ST_ADD   = 2'b01,
    ST_SHIFT = 2'b10,
    ST_HALT  = 2'b11
  } mult_state_e;

  // (N+1)-bit sum of an upper half and the multiplicand
  function automatic logic [8:0] add_upper(input logic [7:0] hi, input logic [7:0] md);
    return {1'b0, hi} + {1'b0, md};
  endfunction
endpackage

// File: rtl/seq_mult_ctrl.sv
module seq_mult_ctrl
  import seq_mult_pkg::*;
#(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output mult_state_e state,
  output logic        last_iter
);
  logic [CW-1:0] iter_q;

  assign last_iter = (iter_q == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_HALT;
      iter_q <= '0;
    end else begin
      unique case (state)
        ST_HALT:  if (start) state <= ST_INIT;
        ST_INIT: begin
          state  <= ST_ADD;
          iter_q <= '0;
        end
        ST_ADD:   state <= ST_SHIFT;
        ST_SHIFT: begin
          if (last_iter) state <= ST_HALT;
          else begin
            state  <= ST_ADD;
            iter_q <= iter_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/seq_mult_datapath.sv
module seq_mult_datapath
  import seq_mult_pkg::*;
#(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  mult_state_e   state,
  input  logic [W-1:0]  mcand,
  input  logic [W-1:0]  mplier,
  output logic [PW-1:0] acc,
  output logic          add_fire
);
  logic [W-1:0] md_q;
  logic         carry_q;
  logic [W:0]   sum;
  logic [PW-1:0] acc_d;
  logic          carry_d;

  assign add_fire = (state == ST_ADD) && acc[0];
  assign sum      = add_upper(acc[PW-1:W], md_q);

  always_comb begin
    acc_d   = acc;
    carry_d = carry_q;
    unique case (state)
      ST_INIT: begin
        acc_d   = {{W{1'b0}}, mplier};
        carry_d = 1'b0;
      end
      ST_ADD: begin
        if (acc[0]) begin
          acc_d   = {sum[W-1:0], acc[W-1:0]};
          carry_d = sum[W];
        end else begin
          carry_d = 1'b0;
        end
      end
      ST_SHIFT: begin
        acc_d   = {carry_q, acc[PW-1:1]};
        carry_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      carry_q <= 1'b0;
      md_q    <= '0;
    end else begin
      acc     <= acc_d;
      carry_q <= carry_d;
      if (state == ST_INIT) md_q <= mcand;
    end
  end
endmodule

// File: rtl/seq_mult.sv
module seq_mult
  import seq_mult_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  mcand,
  input  logic [7:0]  mplier,
  input  logic        start,
  output logic [15:0] product,
  output logic        done
);
  localparam int W = 8;

  mult_state_e state;
  logic        last_iter;
  logic        add_fire;
  logic        run_end;
  logic        run_begin;

  seq_mult_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .state(state), .last_iter(last_iter)
  );

  seq_mult_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .state(state),
    .mcand(mcand), .mplier(mplier),
    .acc(product), .add_fire(add_fire)
  );

  assign done      = (state == ST_HALT);
  assign run_end   = (state == ST_SHIFT) && last_iter;
  assign run_begin = (state == ST_HALT) && start;
endmodule

// File: rtl/seq_mult_checker.sv
module seq_mult_checker (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        done,
  input logic [15:0] product,
  input logic        run_end,
  input logic        run_begin
);
  logic seen_clk;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  assert_reset_state_R1: assert property (@(posedge clk)
    seen_clk && $past(rst) |-> done && product == 16'd0);

  assert_start_leaves_halt_R3: assert property (@(posedge clk) disable iff (rst)
    run_begin |=> !done);

  assert_done_rises_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    run_end |=> done);

  assert_done_only_from_end_R2: assert property (@(posedge clk) disable iff (rst)
    !done ##1 done |-> $past(run_end));

  assert_product_hold_R8: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> $stable(product));
endmodule

bind seq_mult seq_mult_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .product(product),
  .run_end(run_end), .run_begin(run_begin)
);

// File: tb/test_seq_mult.sv
`timescale 1ns/1ps
module test_seq_mult;
  logic        clk = 0;
  logic        rst;
  logic [7:0]  mcand, mplier;
  logic        start;
  logic [15:0] product;
  logic        done;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  seq_mult i_seq_mult (
    .clk(clk), .rst(rst), .mcand(mcand), .mplier(mplier),
    .start(start), .product(product), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one run; start held for one edge; operands scrambled after the sampling edge (R9)
  task automatic run(input logic [7:0] a, input logic [7:0] b, input bit scramble);
    int cyc;
    mcand = a; mplier = b; start = 1;
    @(posedge clk); #5;
    check("R3 done low after start", done, 0);
    @(posedge clk); #5;   // INIT edge latched operands
    start = 0;
    if (scramble) begin mcand = ~a; mplier = a ^ b ^ 8'h5a; start = 1; end
    cyc = 2;
    while (!done && cyc < 40) begin @(posedge clk); #5; cyc++; end
    start = 0;
    check("R7 run length", cyc, 18);
    check("R7 product", product, a * b);
  endtask

  initial begin
    rst = 1; start = 0; mcand = 0; mplier = 0;
    repeat (2) @(posedge clk); #5;
    check("R1 done after reset", done, 1);
    check("R1 product after reset", product, 0);
    rst = 0;
    @(posedge clk); #5;
    check("R2 idle done", done, 1);

    // R4/R5/R6 walk: 3*5, observe states through done and product
    mcand = 8'd3; mplier = 8'd5; start = 1;
    @(posedge clk); #5; start = 0;
    check("R2 INIT done", done, 0);
    @(posedge clk); #5;
    check("R4 init load", product, 16'd5);
    @(posedge clk); #5;
    check("R5 add into upper", product, {8'd3, 8'd5});
    check("R2 ADD done", done, 0);
    @(posedge clk); #5;
    check("R6 shift right", product, {8'd3, 8'd5} >> 1);
    while (!done) begin @(posedge clk); #5; end
    check("R7 walk result", product, 15);

    // R8 hold
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #5;
      check("R8 hold", product, 15);
    end

    // R7 carry corner and exhaustive multiplicand sweep
    run(8'hff, 8'hff, 0);
    for (int a = 0; a < 256; a++) begin
      logic [7:0] bs [6];
      bs = '{8'h00, 8'h01, 8'hff, 8'haa, 8'h55, 8'h80};
      for (int j = 0; j < 6; j++) run(a[7:0], bs[j], (j % 2) == 1); // R9 on odd j
    end

    // R9: start held continuously across back-to-back runs
    mcand = 8'd200; mplier = 8'd17; start = 1;
    for (int r = 0; r < 3; r++) begin
      int cyc = 0;
      @(posedge clk); #5;
      check("R3 continuous start", done, 0);
      cyc = 1;
      @(posedge clk); #5; cyc++;
      mcand = 8'd1; mplier = 8'd1;
      while (!done && cyc < 40) begin @(posedge clk); #5; cyc++; end
      check("R9 continuous product", product, (r == 0) ? 200 * 17 : 1);
      check("R7 continuous length", cyc, 18);
    end
    start = 0;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule